// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Ratio Modes

This block produces the serial clock of an I2C master from a faster reference clock. Each SCL period is built from a low phase, a release window and a high phase. The low and high phases are whole multiples of a time unit. That unit is the programmed divider plus one, in reference cycles. A 2-bit ratio select picks how many units go to the low phase and how many to the high phase. The asymmetric settings let a bus run faster while still meeting the minimum low time.

When the block lets SCL go, it waits a fixed overhead window of eight reference cycles. It also waits until the sampled SCL line reads high. Only then does it count the high phase. A slave that holds the line low therefore pauses the clock. Two single-cycle strobes mark the middle of the low phase, where a bit engine changes SDA, and the middle of the high phase, where it samples SDA.

Divider, ratio and slave flag are captured at the start of each period. A change made mid-period only takes effect from the next period. The interface is control-only: there is no data stream and so no valid/ready handshake. Every pin is a plain level or a one-cycle strobe.

Top module: `scl_rate_gen`

## Requirements
- R1: Ratio select 0 gives a low phase of 4 units and a high phase of 4 units.
- R2: Ratio select 1 gives 6 low units and 3 high units; ratio select 2 gives 11 low units and 6 high units.
- R3: Ratio select 3 behaves exactly like ratio select 0 (4 low, 4 high units).
- R4: One unit lasts divider+1 reference cycles. With SCL following the drive, `scl_drive_low` is high for Nlow*(divider+1) cycles and low for 8+Nhigh*(divider+1) cycles, so one period is (Nlow+Nhigh)*(divider+1)+8 cycles.
- R5: With `slave_mode`=1 a divider of 0 is used as 1. With `slave_mode`=0 a divider of 0 gives a one-cycle unit.
- R6: The high phase starts only after the 8-cycle release window has passed and `scl_in` reads 1. While `scl_in` is held at 0 the drive stays released and `mid_high_strobe` stays 0.
- R7: `mid_low_strobe` pulses once per low phase, in cycle floor(L/2) counted from 0, where L is the low length. `mid_high_strobe` pulses once per high phase, in cycle floor(H/2), where H is the high length.
- R8: While `enable` is 0 (or in reset), from the next cycle on, all three outputs are 0 and the counters are at zero. After `enable` rises, the low phase begins in the next cycle.
- R9: A new divider, ratio or slave value written during a period is applied only from the start of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when 1 |
| div_val | input | DIV_W | Unit divider; a unit lasts div_val+1 cycles |
| ratio_sel | input | 2 | Low/high ratio: 0 standard, 1 asymmetric, 2 fast, 3 same as 0 |
| slave_mode | input | 1 | Forces a minimum divider of 1 when set |
| scl_in | input | 1 | Synchronised SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| mid_low_strobe | output | 1 | One-cycle pulse at the middle of the low phase |
| mid_high_strobe | output | 1 | One-cycle pulse at the middle of the high phase |

## Verification
The bench uses the default 8-bit divider and an 8-cycle overhead. Small divider values (0 to 3) keep every period short, so all four ratio codes, the slave-mode divider floor and a mid-period reconfiguration fit in a few thousand cycles. A bench-side hold on the SCL input pauses the release window. This shows the generator waiting, and then resuming exactly as the reference model predicts.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  localparam int UNIT_W = 4;
endpackage

// File: rtl/scl_ratio_lut.sv
module scl_ratio_lut
  import scl_gen_pkg::*;
(
  input  logic [1:0]        sel_i,
  output logic [UNIT_W-1:0] lo_units_o,
  output logic [UNIT_W-1:0] hi_units_o
);
  always_comb begin
    unique case (sel_i)
      2'd1: begin lo_units_o = UNIT_W'(6);  hi_units_o = UNIT_W'(3); end
      2'd2: begin lo_units_o = UNIT_W'(11); hi_units_o = UNIT_W'(6); end
      default: begin lo_units_o = UNIT_W'(4); hi_units_o = UNIT_W'(4); end
    endcase
  end
endmodule

// File: rtl/scl_span_calc.sv
module scl_span_calc
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + UNIT_W + 1
) (
  input  logic [DIV_W-1:0]  div_i,
  input  logic              slave_i,
  input  logic [UNIT_W-1:0] lo_units_i,
  input  logic [UNIT_W-1:0] hi_units_i,
  output logic [CNT_W-1:0]  low_len_o,
  output logic [CNT_W-1:0]  high_len_o,
  output logic [CNT_W-1:0]  low_mid_o,
  output logic [CNT_W-1:0]  high_mid_o
);
  logic [DIV_W-1:0] eff_div;
  logic [CNT_W-1:0] unit_cyc;

  always_comb begin
    eff_div = div_i;
    if (slave_i && (div_i == '0)) eff_div = DIV_W'(1);
    unit_cyc   = CNT_W'(eff_div) + CNT_W'(1);
    low_len_o  = CNT_W'(lo_units_i) * unit_cyc;
    high_len_o = CNT_W'(hi_units_i) * unit_cyc;
    low_mid_o  = low_len_o >> 1;
    high_mid_o = high_len_o >> 1;
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVH   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       ratio_sel,
  input  logic             slave_mode,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             mid_low_strobe,
  output logic             mid_high_strobe
);
  localparam int CNT_W = DIV_W + UNIT_W + 1;
  localparam logic [CNT_W-1:0] OVH_LAST = CNT_W'(OVH - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic [1:0]       cfg_sel_q;
  logic             cfg_slave_q;

  logic [UNIT_W-1:0] lo_units, hi_units;
  logic [CNT_W-1:0]  low_len, high_len, low_mid, high_mid;
  logic              low_done, high_done, rise_done, start_period;

  scl_ratio_lut u_lut (
    .sel_i      (cfg_sel_q),
    .lo_units_o (lo_units),
    .hi_units_o (hi_units)
  );

  scl_span_calc #(.DIV_W(DIV_W)) u_span (
    .div_i      (cfg_div_q),
    .slave_i    (cfg_slave_q),
    .lo_units_i (lo_units),
    .hi_units_i (hi_units),
    .low_len_o  (low_len),
    .high_len_o (high_len),
    .low_mid_o  (low_mid),
    .high_mid_o (high_mid)
  );

  always_comb begin
    low_done     = (phase_q == PH_LOW)  && (cnt_q == low_len - CNT_W'(1));
    high_done    = (phase_q == PH_HIGH) && (cnt_q == high_len - CNT_W'(1));
    rise_done    = (phase_q == PH_RISE) && (cnt_q >= OVH_LAST) && scl_in;
    start_period = enable && ((phase_q == PH_IDLE) || high_done);
  end

  // configuration capture at period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div_q   <= '0;
      cfg_sel_q   <= '0;
      cfg_slave_q <= 1'b0;
    end else if (start_period) begin
      cfg_div_q   <= div_val;
      cfg_sel_q   <= ratio_sel;
      cfg_slave_q <= slave_mode;
    end
  end

  // phase sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_period) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_LOW: begin
          if (low_done) begin
            phase_q <= PH_RISE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_RISE: begin
          if (rise_done) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else if (cnt_q < OVH_LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: cnt_q <= cnt_q + CNT_W'(1);
        default: cnt_q <= '0;
      endcase
    end
  end

  assign scl_drive_low   = (phase_q == PH_LOW);
  assign mid_low_strobe  = (phase_q == PH_LOW)  && (cnt_q == low_mid);
  assign mid_high_strobe = (phase_q == PH_HIGH) && (cnt_q == high_mid);

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !mid_low_strobe && !mid_high_strobe));

  assert_low_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_len));

  assert_wait_for_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RISE && !scl_in) |=> (phase_q != PH_HIGH));

  assert_strobe_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low_strobe |-> scl_drive_low);

  assert_strobe_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high_strobe |-> (!scl_drive_low && !mid_low_strobe));

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (phase_q == PH_LOW || phase_q == PH_RISE)) |=>
      ($stable(cfg_div_q) && $stable(cfg_sel_q) && $stable(cfg_slave_q)));

  assert_slave_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave_q && cfg_div_q == '0) |-> (low_len == (CNT_W'(lo_units) << 1)));
endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int OVH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic [1:0] ratio_sel = 2'd0;
  logic slave_mode = 1'b0;
  logic hold_low = 1'b0;
  logic scl_in;
  logic scl_drive_low, mid_low_strobe, mid_high_strobe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = !scl_drive_low && !hold_low;

  scl_rate_gen #(.DIV_W(DIV_W), .OVH(OVH)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
    .ratio_sel(ratio_sel), .slave_mode(slave_mode), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .mid_low_strobe(mid_low_strobe),
    .mid_high_strobe(mid_high_strobe)
  );

  // behavioural reference: 0 idle, 1 low, 2 release window, 3 high
  int m_ph = 0, m_cnt = 0, m_L = 0, m_H = 0;

  function automatic int lo_u(input int s);
    return (s == 1) ? 6 : (s == 2) ? 11 : 4;
  endfunction
  function automatic int hi_u(input int s);
    return (s == 1) ? 3 : (s == 2) ? 6 : 4;
  endfunction

  task automatic m_start();
    int d;
    d = int'(div_val);
    if (slave_mode && d == 0) d = 1;
    m_L = lo_u(int'(ratio_sel)) * (d + 1);
    m_H = hi_u(int'(ratio_sel)) * (d + 1);
    m_ph = 1;
    m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      cycles++;
      if (!enable) begin
        m_ph = 0; m_cnt = 0;
      end else begin
        case (m_ph)
          0: m_start();
          1: if (m_cnt == m_L - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
          2: begin
               if (m_cnt >= OVH - 1 && !hold_low) begin m_ph = 3; m_cnt = 0; end
               else if (m_cnt < OVH - 1) m_cnt++;
             end
          default: if (m_cnt == m_H - 1) m_start(); else m_cnt++;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(scl_drive_low == (m_ph == 1), "R4 drive", int'(scl_drive_low), int'(m_ph == 1));
      chk(mid_low_strobe == (m_ph == 1 && m_cnt == m_L / 2), "R7 mid-low strobe",
          int'(mid_low_strobe), int'(m_ph == 1 && m_cnt == m_L / 2));
      chk(mid_high_strobe == (m_ph == 3 && m_cnt == m_H / 2), "R7 mid-high strobe",
          int'(mid_high_strobe), int'(m_ph == 3 && m_cnt == m_H / 2));
    end
  end

  task automatic measure(input int exp_lo, input int exp_rel, input string tag);
    int lo, rel, nml, nmh;
    lo = 0; rel = 0; nml = 0; nmh = 0;
    while (scl_drive_low !== 1'b0) @(negedge clk);
    while (scl_drive_low !== 1'b1) @(negedge clk);
    while (scl_drive_low === 1'b1) begin
      lo++; if (mid_low_strobe) nml++; @(negedge clk);
    end
    while (scl_drive_low === 1'b0) begin
      rel++; if (mid_high_strobe) nmh++; @(negedge clk);
    end
    chk(lo == exp_lo, {tag, " low length"}, lo, exp_lo);
    chk(rel == exp_rel, {tag, " released length"}, rel, exp_rel);
    chk(nml == 1, "R7 one mid-low strobe per period", nml, 1);
    chk(nmh == 1, "R7 one mid-high strobe per period", nmh, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cycles, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lo, nsmp;
    repeat (3) @(negedge clk);
    chk(scl_drive_low == 1'b0 && mid_low_strobe == 1'b0 && mid_high_strobe == 1'b0,
        "R8 reset outputs", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_drive_low == 1'b0, "R8 disabled stays released", int'(scl_drive_low), 0);

    // R1: standard ratio, divider 2
    ratio_sel = 2'd0; div_val = 8'd2; enable = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1'b1, "R8 low begins after enable", int'(scl_drive_low), 1);
    measure(12, 8 + 12, "R1");
    // R2: asymmetric, divider 1
    ratio_sel = 2'd1; div_val = 8'd1;
    measure(12, 8 + 6, "R2 asym");
    // R2/R4: fast, divider 0 (one-cycle unit)
    ratio_sel = 2'd2; div_val = 8'd0;
    measure(11, 8 + 6, "R2 fast R4");
    // R3: undefined code behaves as standard
    ratio_sel = 2'd3; div_val = 8'd3;
    measure(16, 8 + 16, "R3");

    // R9: change divider right at the start of a low phase
    while (scl_drive_low !== 1'b0) @(negedge clk);
    while (scl_drive_low !== 1'b1) @(negedge clk);
    div_val = 8'd0;
    lo = 0;
    while (scl_drive_low === 1'b1) begin lo++; @(negedge clk); end
    chk(lo == 16, "R9 current period keeps old divider", lo, 16);
    measure(4, 8 + 4, "R9 next period R5 master div0");

    // R5: slave mode floors divider 0 to 1
    slave_mode = 1'b1;
    measure(8, 8 + 8, "R5 slave");
    slave_mode = 1'b0;
    measure(4, 8 + 4, "R5 master");

    // R6: hold the line low during the release window
    while (scl_drive_low !== 1'b1) @(negedge clk);
    hold_low = 1'b1;
    while (scl_drive_low !== 1'b0) @(negedge clk);
    nsmp = 0;
    for (int i = 0; i < 30; i++) begin
      if (mid_high_strobe || scl_drive_low) nsmp++;
      @(negedge clk);
    end
    chk(nsmp == 0, "R6 no high phase while held", nsmp, 0);
    hold_low = 1'b0;
    measure(4, 8 + 4, "R6 resumes");

    // R8: disable mid low phase
    while (scl_drive_low !== 1'b1) @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R8 released after disable", int'(scl_drive_low), 0);
    repeat (5) @(negedge clk);
    chk(mid_low_strobe == 1'b0 && mid_high_strobe == 1'b0, "R8 strobes off",
        int'(mid_low_strobe), 0);
    ratio_sel = 2'd1; div_val = 8'd0;
    enable = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1'b1, "R8 restart low", int'(scl_drive_low), 1);
    lo = 1;
    @(negedge clk);
    while (scl_drive_low === 1'b1) begin lo++; @(negedge clk); end
    chk(lo == 6, "R8 restart low length R2", lo, 6);
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule